// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Arbiter

This block resolves sixteen interrupt request lines into one interrupt output and an 8-bit vector. Two identical eight-input priority units are stacked: the upper (master) unit takes request lines 0 to 7 directly, except that its input 2 is taken from the "request pending" output of the lower (slave) unit, which serves request lines 8 to 15. Line 2 is therefore unused, and fifteen priority levels remain. In each unit a lower input index has higher priority, and an input is only raised if its priority is above every level that the unit currently holds in service.

The processor answers the interrupt output with a one-cycle acknowledge strobe. In that cycle the master picks its winning input, marks it in service and places that input's index on an internal 3-bit cascade code. Code 010b selects the slave, which then marks its own winner in service and supplies the vector. Any other code leaves the slave untouched and the master supplies the vector. Each unit has its own end-of-interrupt strobe. That strobe retires the highest-priority level the unit holds in service, so a slave-sourced interrupt is only fully retired after both strobes have been given.

Top module: `cascade_irq_arbiter`

## Requirements
- R1: `int_out` is high, in the same cycle, exactly when some request line's path has a pending request whose level is above every in-service level along that path.
- R2: Overall priority, from highest to lowest, is lines 0, 1, then 8 through 15, then 3 through 7. An acknowledge takes the highest pending one.
- R3: An acknowledge of a master line L (L not 2) sets `vec_out` = {MST_BASE[4:0], L[2:0]} (default 0x08+L) and `cas_out` = L, both visible from the cycle after the strobe and held until the next accepted acknowledge.
- R4: An acknowledge that the master resolves to input 2 drives `cas_out` = 010b, and `vec_out` = {SLV_BASE[4:0], (line-8)[2:0]} (default 0x70+line-8).
- R5: An acknowledge puts the chosen level in service. A request at that level or below it in the same unit then no longer raises `int_out`, while a higher one still does.
- R6: Master in-service bit 2 blocks every slave line and master lines 3 to 7 until a master end-of-interrupt arrives, whatever happens on the slave strobe.
- R7: `eoi_mst` or `eoi_slv` retires only the highest-priority in-service level of its own unit. With nothing in service it has no effect.
- R8: An acknowledge while `int_out` is low is ignored: `vec_out`, `cas_out` and the in-service state stay unchanged.
- R9: An acknowledge and an end-of-interrupt to the same unit in the same cycle both take effect: the old top in-service level is retired and the new winner is put in service.
- R10: Request line 2 has no effect on any output.
- R11: After reset nothing is in service, and `vec_out` and `cas_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 16 | Request lines. 7:0 go to the master (bit 2 unused), 15:8 go to the slave |
| ack | input | 1 | One-cycle interrupt acknowledge strobe |
| eoi_mst | input | 1 | End-of-interrupt strobe for the master unit |
| eoi_slv | input | 1 | End-of-interrupt strobe for the slave unit |
| int_out | output | 1 | Interrupt request towards the processor |
| vec_out | output | 8 | Vector of the last accepted acknowledge |
| cas_out | output | 3 | Cascade code of the last accepted acknowledge |

## Verification
Acknowledge and end-of-interrupt can fall in the same cycle on the master unit. The bench forces this by first putting line 5 in service. It then raises line 3 and asserts `ack` and `eoi_mst` on one clock edge. The result is judged at the ports: the vector must name line 3. Then, with line 3 released and line 5 requested again, `int_out` must stay low until one further master end-of-interrupt, which shows that line 5 was retired in the shared cycle and line 3 took its place.

// File: rtl/irq_cas_pkg.sv
package irq_cas_pkg;
   // Which unit supplies the vector for an acknowledge
   typedef enum logic {
      SRC_MASTER = 1'b0,
      SRC_SLAVE  = 1'b1
   } irq_src_e;
endpackage

// File: rtl/irq_prio_resolve.sv
// Fixed-priority resolver: index 0 highest. Finds the top pending request and
// the top in-service level; a request wins only if strictly above the latter.
module irq_prio_resolve #(
   parameter  int unsigned N  = 8,
   localparam int unsigned LW = $clog2(N),
   localparam int unsigned IW = LW + 1
) (
   input  logic [N-1:0]  req,
   input  logic [N-1:0]  isr,
   output logic          hit,
   output logic [LW-1:0] lvl,
   output logic          top_vld,
   output logic [LW-1:0] top_idx
);
   logic [IW-1:0] r_idx;
   logic [IW-1:0] s_idx;

   always_comb begin
      r_idx = IW'(N);
      s_idx = IW'(N);
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) r_idx = IW'(i);
         if (isr[i]) s_idx = IW'(i);
      end
   end

   assign hit     = (r_idx < s_idx);
   assign lvl     = r_idx[LW-1:0];
   assign top_vld = (s_idx != IW'(N));
   assign top_idx = s_idx[LW-1:0];
endmodule

// File: rtl/irq_ctrl_unit.sv
// One priority unit: in-service register plus resolver. Acknowledge and
// end-of-interrupt merge into a single next-state expression.
module irq_ctrl_unit #(
   parameter  int unsigned N  = 8,
   localparam int unsigned LW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          take,
   input  logic          eoi,
   output logic          hit,
   output logic [LW-1:0] lvl,
   output logic [N-1:0]  isr
);
   logic          top_vld;
   logic [LW-1:0] top_idx;
   logic [N-1:0]  set_m;
   logic [N-1:0]  clr_m;
   logic [N-1:0]  isr_q;

   irq_prio_resolve #(.N(N)) u_res (
      .req     (req),
      .isr     (isr_q),
      .hit     (hit),
      .lvl     (lvl),
      .top_vld (top_vld),
      .top_idx (top_idx)
   );

   always_comb begin
      set_m = '0;
      clr_m = '0;
      if (take && hit)    set_m[lvl]     = 1'b1;
      if (eoi && top_vld) clr_m[top_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~clr_m) | set_m;
   end

   assign isr = isr_q;
endmodule

// File: rtl/cascade_irq_arbiter.sv
module cascade_irq_arbiter
   import irq_cas_pkg::*;
#(
   parameter  int unsigned N_LINES  = 8,
   parameter  int unsigned VEC_W    = 8,
   parameter  int unsigned CAS_PORT = 2,
   parameter  int unsigned MST_BASE = 1,
   parameter  int unsigned SLV_BASE = 14,
   localparam int unsigned LW       = $clog2(N_LINES),
   localparam int unsigned BW       = VEC_W - LW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*N_LINES-1:0] irq_req,
   input  logic                 ack,
   input  logic                 eoi_mst,
   input  logic                 eoi_slv,
   output logic                 int_out,
   output logic [VEC_W-1:0]     vec_out,
   output logic [LW-1:0]        cas_out
);
   // Elaboration-time parameter checks
   if (N_LINES < 2 || (1 << LW) != N_LINES) begin : g_bad_lines
      $error("N_LINES must be a power of two, at least 2");
   end
   if (CAS_PORT >= N_LINES) begin : g_bad_port
      $error("CAS_PORT must name a master input");
   end
   if (VEC_W <= LW) begin : g_bad_vecw
      $error("VEC_W must exceed the level width");
   end
   if (MST_BASE >= (1 << BW) || SLV_BASE >= (1 << BW) || MST_BASE == SLV_BASE) begin : g_bad_base
      $error("vector bases must fit and differ");
   end

   logic               s_hit, m_hit;
   logic [LW-1:0]      s_lvl, m_lvl;
   logic [N_LINES-1:0] s_isr, m_isr, m_req;
   logic               s_take;
   irq_src_e           src;
   logic [VEC_W-1:0]   vec_q;
   logic [LW-1:0]      cas_q;

   always_comb begin
      m_req           = irq_req[N_LINES-1:0];
      m_req[CAS_PORT] = s_hit;
   end

   assign src    = (m_lvl == LW'(CAS_PORT)) ? SRC_SLAVE : SRC_MASTER;
   assign s_take = ack && m_hit && (src == SRC_SLAVE);

   irq_ctrl_unit #(.N(N_LINES)) u_slv (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (irq_req[2*N_LINES-1:N_LINES]),
      .take  (s_take),
      .eoi   (eoi_slv),
      .hit   (s_hit),
      .lvl   (s_lvl),
      .isr   (s_isr)
   );

   irq_ctrl_unit #(.N(N_LINES)) u_mst (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (m_req),
      .take  (ack),
      .eoi   (eoi_mst),
      .hit   (m_hit),
      .lvl   (m_lvl),
      .isr   (m_isr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
         cas_q <= '0;
      end else if (ack && m_hit) begin
         cas_q <= m_lvl;
         vec_q <= (src == SRC_SLAVE) ? {BW'(SLV_BASE), s_lvl} : {BW'(MST_BASE), m_lvl};
      end
   end

   assign int_out = m_hit;
   assign vec_out = vec_q;
   assign cas_out = cas_q;
endmodule

// File: rtl/cascade_irq_chk.sv
module cascade_irq_chk #(
   parameter  int unsigned N_LINES  = 8,
   parameter  int unsigned VEC_W    = 8,
   parameter  int unsigned CAS_PORT = 2,
   parameter  int unsigned MST_BASE = 1,
   parameter  int unsigned SLV_BASE = 14,
   localparam int unsigned LW       = $clog2(N_LINES),
   localparam int unsigned BW       = VEC_W - LW
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ack,
   input logic               eoi_mst,
   input logic               eoi_slv,
   input logic               int_out,
   input logic [VEC_W-1:0]   vec_out,
   input logic [LW-1:0]      cas_out,
   input logic [N_LINES-1:0] m_isr,
   input logic [N_LINES-1:0] s_isr,
   input logic [LW-1:0]      m_lvl
);
   // R8: a refused acknowledge leaves the outputs alone
   assert_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !int_out) |=> ($stable(vec_out) && $stable(cas_out)));

   // R3: master vector carries master base and the cascade code as level
   assert_mst_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && int_out && m_lvl != LW'(CAS_PORT)) |=>
         (vec_out[LW-1:0] == cas_out && vec_out[VEC_W-1:LW] == BW'(MST_BASE)));

   // R4: the slave code and the slave base go together
   assert_slv_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && int_out) |=> ((cas_out == LW'(CAS_PORT)) == (vec_out[VEC_W-1:LW] == BW'(SLV_BASE))));

   // R5: an accepted acknowledge adds exactly one master in-service level
   assert_ack_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && int_out && !eoi_mst) |=> (int'($countones(m_isr)) == int'($countones($past(m_isr))) + 1));

   // R7: master end-of-interrupt retires at most one level
   assert_eoi_mst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_mst && !ack) |=>
         (int'($countones(m_isr)) == int'($countones($past(m_isr))) - int'($past(m_isr) != '0)));

   // R7: slave end-of-interrupt without a slave acknowledge retires at most one level
   assert_eoi_slv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_slv && !ack) |=>
         (int'($countones(s_isr)) == int'($countones($past(s_isr))) - int'($past(s_isr) != '0)));
endmodule

bind cascade_irq_arbiter cascade_irq_chk #(
   .N_LINES  (N_LINES),
   .VEC_W    (VEC_W),
   .CAS_PORT (CAS_PORT),
   .MST_BASE (MST_BASE),
   .SLV_BASE (SLV_BASE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ack     (ack),
   .eoi_mst (eoi_mst),
   .eoi_slv (eoi_slv),
   .int_out (int_out),
   .vec_out (vec_out),
   .cas_out (cas_out),
   .m_isr   (m_isr),
   .s_isr   (s_isr),
   .m_lvl   (m_lvl)
);

// File: tb/sim_cascade_irq_arbiter.sv
`timescale 1ns/1ps
module sim_cascade_irq_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_req = '0;
   logic        ack = 1'b0;
   logic        eoi_mst = 1'b0;
   logic        eoi_slv = 1'b0;
   logic        int_out;
   logic [7:0]  vec_out;
   logic [2:0]  cas_out;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   cascade_irq_arbiter u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_req (irq_req),
      .ack     (ack),
      .eoi_mst (eoi_mst),
      .eoi_slv (eoi_slv),
      .int_out (int_out),
      .vec_out (vec_out),
      .cas_out (cas_out)
   );

   // {request lines, expected vector, expected cascade code}
   localparam int NV = 12;
   localparam logic [26:0] TBL [NV] = '{
      {16'h0001, 8'h08, 3'd0},   // R3 line 0
      {16'h0002, 8'h09, 3'd1},   // R3 line 1
      {16'h0100, 8'h70, 3'd2},   // R4 line 8
      {16'h8000, 8'h77, 3'd2},   // R4 line 15
      {16'h0080, 8'h0F, 3'd7},   // R3 line 7
      {16'h0008, 8'h0B, 3'd3},   // R3 line 3
      {16'h0108, 8'h70, 3'd2},   // R2 slave over line 3
      {16'h0102, 8'h09, 3'd1},   // R2 line 1 over slave
      {16'h8080, 8'h77, 3'd2},   // R2 line 15 over line 7
      {16'h0030, 8'h0C, 3'd4},   // R2 line 4 over 5
      {16'h0A00, 8'h71, 3'd2},   // R2 line 9 over 11
      {16'h0005, 8'h08, 3'd0}    // R10 line 2 beside line 0
   };

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      cyc();
      ack = 1'b0;
   endtask

   task automatic do_eoi(logic m, logic s);
      eoi_mst = m;
      eoi_slv = s;
      cyc();
      eoi_mst = 1'b0;
      eoi_slv = 1'b0;
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] old_vec;
      logic [2:0] old_cas;
      repeat (3) cyc();
      // R11 reset state
      chk("R11 vec after reset", 16'(vec_out), 16'h00);
      chk("R11 cas after reset", 16'(cas_out), 16'h0);
      chk("R11 int idle", 16'(int_out), 16'h0);
      rst_n = 1'b1;
      cyc();
      chk("R11 int idle after release", 16'(int_out), 16'h0);

      // Table walk
      for (int k = 0; k < NV; k++) begin
         irq_req = TBL[k][26:11];
         #1;
         chk("R1 int raised", 16'(int_out), 16'h1);
         cyc();
         do_ack();
         chk("R2/R3/R4 vector", 16'(vec_out), 16'(TBL[k][10:3]));
         chk("R3/R4 cascade", 16'(cas_out), 16'(TBL[k][2:0]));
         irq_req = '0;
         do_eoi(1'b1, 1'b1);
      end

      // R10 line 2 alone, R8 refused acknowledge
      irq_req = 16'h0004;
      #1;
      chk("R10 line 2 alone no int", 16'(int_out), 16'h0);
      old_vec = vec_out;
      old_cas = cas_out;
      cyc();
      do_ack();
      chk("R8 vec unchanged", 16'(vec_out), 16'(old_vec));
      chk("R8 cas unchanged", 16'(cas_out), 16'(old_cas));
      irq_req = 16'h0080;
      #1;
      chk("R8 no level went in service", 16'(int_out), 16'h1);
      irq_req = '0;
      cyc();

      // R5 nesting in the master
      irq_req = 16'h0020;
      cyc();
      do_ack();
      chk("R5 vec line 5", 16'(vec_out), 16'h0D);
      #1;
      chk("R5 same level blocked", 16'(int_out), 16'h0);
      irq_req = 16'h0060;
      #1;
      chk("R5 lower level blocked", 16'(int_out), 16'h0);
      irq_req = 16'h0068;
      #1;
      chk("R5 higher level passes", 16'(int_out), 16'h1);
      cyc();
      do_ack();
      chk("R5 nested vec line 3", 16'(vec_out), 16'h0B);
      do_eoi(1'b1, 1'b0);
      #1;
      chk("R7 top level retired, line 3 again", 16'(int_out), 16'h1);
      irq_req = 16'h0040;
      #1;
      chk("R7 line 5 still in service", 16'(int_out), 16'h0);
      cyc();
      do_eoi(1'b1, 1'b0);
      #1;
      chk("R7 all retired", 16'(int_out), 16'h1);
      irq_req = '0;
      do_eoi(1'b1, 1'b1);
      irq_req = 16'h0040;
      #1;
      chk("R7 eoi on empty no effect", 16'(int_out), 16'h1);
      irq_req = '0;
      cyc();

      // R6 master bit 2 blocks until the master strobe
      irq_req = 16'h0100;
      cyc();
      do_ack();
      chk("R6 slave vec", 16'(vec_out), 16'h70);
      irq_req = 16'h0010;
      #1;
      chk("R6 line 4 blocked", 16'(int_out), 16'h0);
      cyc();
      do_eoi(1'b0, 1'b1);
      #1;
      chk("R6 still blocked after slave eoi", 16'(int_out), 16'h0);
      irq_req = 16'h0200;
      #1;
      chk("R6 slave line 9 blocked", 16'(int_out), 16'h0);
      cyc();
      do_eoi(1'b1, 1'b0);
      #1;
      chk("R6 released by master eoi", 16'(int_out), 16'h1);
      do_ack();
      chk("R6 slave line 9 vec", 16'(vec_out), 16'h71);
      // R7 master strobe alone leaves slave level 9 in service
      do_eoi(1'b1, 1'b0);
      irq_req = 16'h0400;
      #1;
      chk("R7 slave level 9 still blocks 10", 16'(int_out), 16'h0);
      irq_req = 16'h0010;
      #1;
      chk("R7 master line 4 free", 16'(int_out), 16'h1);
      irq_req = '0;
      cyc();
      do_eoi(1'b0, 1'b1);

      // R9 acknowledge and master end-of-interrupt in one cycle
      irq_req = 16'h0020;
      cyc();
      do_ack();
      irq_req = 16'h0028;
      ack = 1'b1;
      eoi_mst = 1'b1;
      cyc();
      ack = 1'b0;
      eoi_mst = 1'b0;
      chk("R9 vec line 3", 16'(vec_out), 16'h0B);
      irq_req = 16'h0020;
      #1;
      chk("R9 line 3 in service", 16'(int_out), 16'h0);
      cyc();
      do_eoi(1'b1, 1'b0);
      #1;
      chk("R9 line 5 was retired in shared cycle", 16'(int_out), 16'h1);
      irq_req = '0;
      cyc();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule